// File: doc/BRIEF.md
# Multi-Mode Timer with Polarity Control

This block is a single 16-bit up-counter that software configures with one write strobe. The write loads an enable bit, a polarity bit, a three-bit mode code, a reload limit and a compare/PWM value, and it restarts the count at 1. The timer serves eight modes: one-shot and continuous periodic timing, counting external edges, a single PWM output, capturing the count on an input edge, matching against a compare value, counting while the input is at a level, and a capture/compare mode that waits for a first edge before it runs. In every mode the count wraps back to 1 after it reaches its limit, and the wrap raises a one-cycle interrupt pulse.

The single polarity bit has a different meaning in each mode. It sets the idle level of the output pin, the edge of the external input that counts or captures, or the input level that lets gated counting proceed. The external input is asynchronous. It passes through two synchronizing flops, and then an edge detector, before any logic uses it. As a result, an input change takes effect on the third rising clock edge after the change.

Top module: `mtimer_top`

## Requirements
- R1: After synchronous reset, countVal is 1, tmrOut, irq and enOut are 0, and capVal is 0.
- R2: A cycle with cfgWr high loads every configuration field and sets the count to 1. While enOut is 0, tmrOut equals the loaded polarity, the count stays put, irq stays low, and input edges have no effect.
- R3: Continuous mode (code 1) advances the count by one each clock. When the count equals cfgReload, the next edge sets the count to 1, pulses irq for one cycle and inverts tmrOut. The period is therefore cfgReload clocks, starting from tmrOut equal to the polarity.
- R4: One-shot mode (code 0) behaves like continuous mode until its first wrap. At that wrap, enOut clears by itself. tmrOut shows the inverted level for one cycle and then returns to the polarity, and the count stays at 1.
- R5: Counter mode (code 2) adds one per active input edge: rising edges when the polarity is 0, falling edges when it is 1. An input change moves the count at the third rising clock edge after the change, not earlier.
- R6: PWM mode (code 3) counts like continuous mode. The tick on which the count equals cfgCmp drives tmrOut to the inverse of the polarity. The wrap drives it back to the polarity, and the wrap wins when both occur together.
- R7: Capture mode (code 4) counts each clock. An active input edge (rising when the polarity is 0, falling when it is 1) copies the count into capVal and pulses irq. The copied value is the count seen two clocks after the input change. capVal holds this value until the next capture.
- R8: Gated mode (code 6) counts only while the synchronized input is high (polarity 0) or low (polarity 1). The edge that ends the gate pulses irq: falling for polarity 0, rising for polarity 1.
- R9: Capture/compare mode (code 7) holds the count at 1 until the first active edge. That edge starts counting and raises no irq. Each later active edge captures the count the same way as in R7 and pulses irq.
- R10: Compare mode (code 5) behaves like continuous mode but wraps and toggles when the count reaches cfgCmp instead of cfgReload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgWr | input | 1 | Configuration write strobe |
| cfgEn | input | 1 | Enable value loaded by a write |
| cfgPol | input | 1 | Polarity value loaded by a write |
| cfgMode | input | 3 | Mode code loaded by a write |
| cfgReload | input | W | Reload limit loaded by a write |
| cfgCmp | input | W | Compare/PWM value loaded by a write |
| tmrIn | input | 1 | Asynchronous external timer input |
| tmrOut | output | 1 | Timer output pin |
| irq | output | 1 | One-cycle interrupt pulse |
| capVal | output | W | Captured count |
| countVal | output | W | Current count |
| enOut | output | 1 | Current enable state |

## Verification
Capture/compare mode is the hardest to reach. It has an armed-but-idle phase, and only the first active edge ends that phase. A run of the wrong edge in between must change neither the count nor capVal. The bench reaches this state by holding the input at the level that is inactive for the chosen polarity when it writes the configuration. It then sends a start edge, an ignored edge of the opposite direction, and a capturing edge, all spaced well beyond the synchronizer latency. The expected captured value is the count read at the moment the input changes, plus two.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

  typedef enum logic [2:0] {
    MD_ONESHOT = 3'd0,
    MD_CONT    = 3'd1,
    MD_COUNTER = 3'd2,
    MD_PWM     = 3'd3,
    MD_CAPTURE = 3'd4,
    MD_COMPARE = 3'd5,
    MD_GATED   = 3'd6,
    MD_CAPCMP  = 3'd7
  } tmode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // configuration write this cycle
    logic tick;     // advance the count
    logic grab;     // copy count into capture register
    logic sideIrq;  // interrupt not caused by a wrap
    logic pol;      // effective polarity
    logic idle;     // timer disabled: output parks at polarity
    logic pwm;      // PWM output behaviour
    logic useCmp;   // wrap on compare value instead of reload
  } strobe_t;

endpackage

// File: rtl/mtimer_ctrl.sv
module mtimer_ctrl
  import mtimer_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    cfgWr,
  input  logic    cfgEn,
  input  logic    cfgPol,
  input  tmode_e  cfgMode,
  input  logic    tmrIn,
  input  logic    wrapEvt,
  output strobe_t strb,
  output logic    enQ,
  output tmode_e  modeQ
);

  localparam int SYNC_STAGES = 3;

  logic [SYNC_STAGES-1:0] syncQ;
  logic polQ;
  logic started;
  logic lvl, prevLvl, riseEdge, fallEdge;
  logic actEdge, endEdge, gateOn, run;

  always_ff @(posedge clk) begin
    if (rst) syncQ <= '0;
    else     syncQ <= {syncQ[SYNC_STAGES-2:0], tmrIn};
  end

  assign lvl      = syncQ[SYNC_STAGES-2];
  assign prevLvl  = syncQ[SYNC_STAGES-1];
  assign riseEdge = lvl & ~prevLvl;
  assign fallEdge = ~lvl & prevLvl;
  assign actEdge  = polQ ? fallEdge : riseEdge;
  assign endEdge  = polQ ? riseEdge : fallEdge;
  assign gateOn   = lvl ^ polQ;
  assign run      = enQ & ~cfgWr;

  always_ff @(posedge clk) begin
    if (rst) begin
      enQ     <= 1'b0;
      polQ    <= 1'b0;
      modeQ   <= MD_ONESHOT;
      started <= 1'b0;
    end else if (cfgWr) begin
      enQ     <= cfgEn;
      polQ    <= cfgPol;
      modeQ   <= cfgMode;
      started <= 1'b0;
    end else begin
      if (modeQ == MD_ONESHOT && wrapEvt) enQ <= 1'b0;
      if (modeQ == MD_CAPCMP && run && actEdge) started <= 1'b1;
    end
  end

  always_comb begin
    strb         = '0;
    strb.load    = cfgWr;
    strb.pol     = cfgWr ? cfgPol : polQ;
    strb.idle    = ~enQ;
    strb.pwm     = (modeQ == MD_PWM);
    strb.useCmp  = (modeQ == MD_COMPARE);
    unique case (modeQ)
      MD_COUNTER: strb.tick = run & actEdge;
      MD_GATED: begin
        strb.tick    = run & gateOn;
        strb.sideIrq = run & endEdge;
      end
      MD_CAPTURE: begin
        strb.tick = run;
        strb.grab = run & actEdge;
      end
      MD_CAPCMP: begin
        strb.tick = run & started;
        strb.grab = run & started & actEdge;
      end
      default: strb.tick = run;
    endcase
  end

endmodule

// File: rtl/mtimer_dp.sv
module mtimer_dp
  import mtimer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  strobe_t      strb,
  input  logic [W-1:0] cfgReload,
  input  logic [W-1:0] cfgCmp,
  output logic [W-1:0] countVal,
  output logic [W-1:0] capVal,
  output logic         tmrOut,
  output logic         irq,
  output logic         wrapEvt
);

  localparam logic [W-1:0] CNT_START = W'(1);

  logic [W-1:0] reloadQ, cmpQ, limit;
  logic pwmHit;

  assign limit   = strb.useCmp ? cmpQ : reloadQ;
  assign wrapEvt = strb.tick & (countVal == limit);
  assign pwmHit  = strb.tick & strb.pwm & (countVal == cmpQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      reloadQ  <= '0;
      cmpQ     <= '0;
      countVal <= CNT_START;
      capVal   <= '0;
      tmrOut   <= 1'b0;
      irq      <= 1'b0;
    end else begin
      irq <= wrapEvt | strb.grab | strb.sideIrq;
      if (strb.load) begin
        reloadQ  <= cfgReload;
        cmpQ     <= cfgCmp;
        countVal <= CNT_START;
        tmrOut   <= strb.pol;
      end else begin
        if (wrapEvt)        countVal <= CNT_START;
        else if (strb.tick) countVal <= countVal + W'(1);
        if (strb.grab) capVal <= countVal;
        if (strb.idle)    tmrOut <= strb.pol;
        else if (wrapEvt) tmrOut <= strb.pwm ? strb.pol : ~tmrOut;
        else if (pwmHit)  tmrOut <= ~strb.pol;
      end
    end
  end

endmodule

// File: rtl/mtimer_top.sv
module mtimer_top
  import mtimer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfgWr,
  input  logic         cfgEn,
  input  logic         cfgPol,
  input  logic [2:0]   cfgMode,
  input  logic [W-1:0] cfgReload,
  input  logic [W-1:0] cfgCmp,
  input  logic         tmrIn,
  output logic         tmrOut,
  output logic         irq,
  output logic [W-1:0] capVal,
  output logic [W-1:0] countVal,
  output logic         enOut
);

  strobe_t strb;
  tmode_e  modeQ;
  logic    wrapEvt;

  mtimer_ctrl ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .cfgWr   (cfgWr),
    .cfgEn   (cfgEn),
    .cfgPol  (cfgPol),
    .cfgMode (tmode_e'(cfgMode)),
    .tmrIn   (tmrIn),
    .wrapEvt (wrapEvt),
    .strb    (strb),
    .enQ     (enOut),
    .modeQ   (modeQ)
  );

  mtimer_dp #(.W(W)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .cfgReload (cfgReload),
    .cfgCmp    (cfgCmp),
    .countVal  (countVal),
    .capVal    (capVal),
    .tmrOut    (tmrOut),
    .irq       (irq),
    .wrapEvt   (wrapEvt)
  );

endmodule

// File: rtl/mtimer_chk.sv
module mtimer_chk
  import mtimer_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         cfgWr,
  input logic         irq,
  input logic         enOut,
  input logic         tmrOut,
  input logic [W-1:0] countVal,
  input logic [W-1:0] capVal,
  input logic         wrapEvt,
  input strobe_t      strb,
  input tmode_e       modeQ
);

  // R1: state right after reset
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (countVal == W'(1) && !irq && !enOut && !tmrOut && capVal == '0));

  // R2: a disabled timer without a write keeps its count and stays quiet
  a_r2_hold_when_off: assert property (@(posedge clk) disable iff (rst)
    (!enOut && !cfgWr) |=> ($stable(countVal) && !irq));

  // R3: a wrap restarts at 1 and pulses the interrupt
  a_r3_wrap_restart: assert property (@(posedge clk) disable iff (rst)
    wrapEvt |=> (countVal == W'(1) && irq));

  // R4: one-shot disables itself at its wrap
  a_r4_oneshot_stop: assert property (@(posedge clk) disable iff (rst)
    (wrapEvt && modeQ == MD_ONESHOT) |=> !enOut);

  // R7: a capture pulses the interrupt
  a_r7_capture_irq: assert property (@(posedge clk) disable iff (rst)
    strb.grab |=> irq);

endmodule

bind mtimer_top mtimer_chk #(.W(W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .cfgWr    (cfgWr),
  .irq      (irq),
  .enOut    (enOut),
  .tmrOut   (tmrOut),
  .countVal (countVal),
  .capVal   (capVal),
  .wrapEvt  (wrapEvt),
  .strb     (strb),
  .modeQ    (modeQ)
);

// File: tb/mtimer_top_tb_top.sv
`timescale 1ns/1ps
module mtimer_top_tb_top;

  localparam int W = 16;
  localparam logic [2:0] M_ONE = 3'd0, M_CONT = 3'd1, M_CNT = 3'd2, M_PWM = 3'd3,
                         M_CAP = 3'd4, M_CMP = 3'd5, M_GATE = 3'd6, M_CC = 3'd7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgWr = 1'b0, cfgEn = 1'b0, cfgPol = 1'b0;
  logic [2:0] cfgMode = '0;
  logic [W-1:0] cfgReload = '0, cfgCmp = '0;
  logic tmrIn = 1'b0;
  logic tmrOut, irq, enOut;
  logic [W-1:0] capVal, countVal;

  int nChecks = 0;
  int nErr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mtimer_top #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .cfgWr(cfgWr), .cfgEn(cfgEn), .cfgPol(cfgPol),
    .cfgMode(cfgMode), .cfgReload(cfgReload), .cfgCmp(cfgCmp), .tmrIn(tmrIn),
    .tmrOut(tmrOut), .irq(irq), .capVal(capVal), .countVal(countVal), .enOut(enOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic en, input logic pol, input logic [2:0] md,
                     input int rl, input int cv);
    @(negedge clk);
    cfgEn = en; cfgPol = pol; cfgMode = md;
    cfgReload = W'(rl); cfgCmp = W'(cv); cfgWr = 1'b1;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  initial begin : wd
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nErr++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
      $finish;
    end
  end

  initial begin : main
    int c;
    cyc(3);
    rst = 1'b0;
    // R1
    chk("R1 count", countVal, 1);
    chk("R1 out", tmrOut, 0);
    chk("R1 irq", irq, 0);
    chk("R1 cap", capVal, 0);
    chk("R1 en", enOut, 0);

    // R2: disabled counter mode ignores input edges
    cfg(0, 1, M_CNT, 10, 0);
    chk("R2 out", tmrOut, 1);
    chk("R2 en", enOut, 0);
    for (int i = 0; i < 4; i++) begin
      tmrIn = ~tmrIn;
      cyc(4);
      chk("R2 count", countVal, 1);
      chk("R2 irq", irq, 0);
    end

    // R3: continuous sweep
    for (int p = 0; p < 2; p++) begin
      for (int r = 1; r <= 6; r++) begin
        cfg(1, p[0], M_CONT, r, 0);
        chk("R3 start out", tmrOut, p);
        chk("R3 start count", countVal, 1);
        for (int k = 1; k <= 2 * r + 1; k++) begin
          cyc(1);
          chk("R3 count", countVal, (k % r) + 1);
          chk("R3 irq", irq, (k % r) == 0);
          chk("R3 out", tmrOut, p ^ ((k / r) & 1));
        end
      end
    end

    // R10: compare mode wraps on compare value
    cfg(1, 0, M_CMP, 50, 4);
    for (int k = 1; k <= 9; k++) begin
      cyc(1);
      chk("R10 count", countVal, (k % 4) + 1);
      chk("R10 irq", irq, (k % 4) == 0);
      chk("R10 out", tmrOut, (k / 4) & 1);
    end

    // R4: one-shot
    cfg(1, 0, M_ONE, 5, 0);
    cyc(4);
    chk("R4 count", countVal, 5);
    chk("R4 en", enOut, 1);
    cyc(1);
    chk("R4 wrap count", countVal, 1);
    chk("R4 wrap irq", irq, 1);
    chk("R4 en cleared", enOut, 0);
    chk("R4 toggled", tmrOut, 1);
    cyc(1);
    chk("R4 back out", tmrOut, 0);
    chk("R4 irq low", irq, 0);
    cyc(10);
    chk("R4 stopped", countVal, 1);
    chk("R4 no irq", irq, 0);

    // R6: PWM sweep
    for (int p = 0; p < 2; p++) begin
      for (int r = 2; r <= 5; r++) begin
        for (int q = 1; q <= r; q++) begin
          cfg(1, p[0], M_PWM, r, q);
          chk("R6 start", tmrOut, p);
          for (int k = 1; k <= 2 * r; k++) begin
            int m;
            cyc(1);
            m = ((k - 1) % r) + 1;
            chk("R6 out", tmrOut, p ^ int'(q <= m && m < r));
          end
        end
      end
      cfg(0, p[0], M_PWM, 4, 2);
      cyc(1);
      chk("R6 disabled out", tmrOut, p);
    end

    // R5: counter mode with latency
    tmrIn = 1'b0;
    cyc(4);
    for (int p = 0; p < 2; p++) begin
      cfg(1, p[0], M_CNT, 100, 0);
      for (int i = 0; i < 3; i++) begin
        tmrIn = 1'b1;
        cyc(2);
        chk("R5 rise early", countVal, 1 + i);
        cyc(1);
        chk("R5 rise", countVal, (p == 0) ? 2 + i : 1 + i);
        cyc(1);
        tmrIn = 1'b0;
        cyc(2);
        chk("R5 fall early", countVal, (p == 0) ? 2 + i : 1 + i);
        cyc(1);
        chk("R5 fall", countVal, 2 + i);
        cyc(1);
      end
    end

    // R7: capture
    cfg(1, 0, M_CAP, 1000, 0);
    cyc(5);
    c = int'(countVal);
    tmrIn = 1'b1;
    cyc(2);
    chk("R7 irq early", irq, 0);
    cyc(1);
    chk("R7 cap rise", capVal, c + 2);
    chk("R7 irq", irq, 1);
    cyc(1);
    chk("R7 irq single", irq, 0);
    tmrIn = 1'b0;
    for (int i = 0; i < 5; i++) begin
      cyc(1);
      chk("R7 fall ignored irq", irq, 0);
    end
    chk("R7 cap held", capVal, c + 2);
    cfg(1, 1, M_CAP, 1000, 0);
    tmrIn = 1'b1;
    cyc(5);
    chk("R7 rise ignored pol1", capVal, c + 2);
    c = int'(countVal);
    tmrIn = 1'b0;
    cyc(3);
    chk("R7 cap fall", capVal, c + 2);
    chk("R7 irq pol1", irq, 1);

    // R8: gated
    cyc(4);
    cfg(1, 0, M_GATE, 1000, 0);
    cyc(5);
    chk("R8 gate closed", countVal, 1);
    tmrIn = 1'b1;
    cyc(7);
    chk("R8 gate open", countVal, 6);
    tmrIn = 1'b0;
    cyc(2);
    chk("R8 irq early", irq, 0);
    cyc(1);
    chk("R8 irq fall", irq, 1);
    chk("R8 count", countVal, 8);
    cyc(5);
    chk("R8 held", countVal, 8);
    chk("R8 irq low", irq, 0);
    cfg(1, 1, M_GATE, 1000, 0);
    cyc(4);
    chk("R8 pol1 open", countVal, 5);
    tmrIn = 1'b1;
    cyc(2);
    chk("R8 pol1 irq early", irq, 0);
    cyc(1);
    chk("R8 pol1 irq rise", irq, 1);
    chk("R8 pol1 count", countVal, 7);
    cyc(5);
    chk("R8 pol1 held", countVal, 7);

    // R9: capture/compare, polarity 0
    tmrIn = 1'b0;
    cyc(4);
    cfg(1, 0, M_CC, 1000, 0);
    cyc(6);
    chk("R9 armed", countVal, 1);
    tmrIn = 1'b1;
    cyc(3);
    chk("R9 start count", countVal, 1);
    chk("R9 start no irq", irq, 0);
    cyc(2);
    chk("R9 running", countVal, 3);
    c = int'(capVal);
    tmrIn = 1'b0;
    cyc(4);
    chk("R9 fall ignored", countVal, 7);
    chk("R9 cap kept", capVal, c);
    tmrIn = 1'b1;
    cyc(3);
    chk("R9 capture", capVal, 9);
    chk("R9 irq", irq, 1);
    // polarity 1
    cfg(1, 1, M_CC, 1000, 0);
    cyc(4);
    chk("R9 pol1 armed", countVal, 1);
    tmrIn = 1'b0;
    cyc(3);
    chk("R9 pol1 start", countVal, 1);
    cyc(2);
    chk("R9 pol1 running", countVal, 3);
    tmrIn = 1'b1;
    cyc(6);
    chk("R9 pol1 rise ignored", capVal, 9);
    c = int'(countVal);
    chk("R9 pol1 count", c, 9);
    tmrIn = 1'b0;
    cyc(3);
    chk("R9 pol1 capture", capVal, 11);
    chk("R9 pol1 irq", irq, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end

endmodule